// File: doc/BRIEF.md
# Conversion Sample Queue with Two-Byte Host Readout

This block stores 12-bit converter results during hardware-paced acquisition. It hands them to an 8-bit host bus as a pair of byte reads. Each completed conversion arrives as a one-cycle strobe together with its result. While hardware pacing is enabled, the result is pushed into a queue of `DEPTH` entries.

The host reads the low byte first and the high byte second. The low byte carries the bottom four data bits, an overflow flag and an empty flag. It also captures the whole head entry, so that the high byte that follows returns the matching upper eight bits. The entry leaves the queue on the high-byte read. When the queue is empty, a read returns the most recently stored sample with the empty flag set. When the queue is full, a new sample evicts the oldest entry and sets a sticky overflow flag. That flag and the queue pointers are cleared only when hardware pacing is switched on again.

When hardware pacing is off (software mode), the queue is bypassed. Both bytes then come straight from the latest conversion result, and both flags read 0.

Top module: `cvt_sample_fifo`

## Requirements
- R1: After synchronous reset, `rd_data` is 0, the queue is empty, the overflow flag is 0 and the last-stored sample is 0.
- R2: In hardware mode a low-byte read returns bits [7:4] = sample[3:0], bits [3:2] = 0, bit [1] = overflow flag, and bit [0] = empty flag (1 = empty).
- R3: A high-byte read in hardware mode returns bits [11:4] of the sample captured by the preceding low-byte read. It removes the head entry only if that low read captured a stored entry.
- R4: Up to `DEPTH` (default 16) samples are held without loss and are read back in arrival order.
- R5: With the queue empty, a low read returns the most recently stored sample with the empty flag at 1. The high read returns that sample's upper bits, and nothing is removed.
- R6: A sample arriving while the queue is full overwrites the oldest entry, so the newest `DEPTH` samples remain. The overflow flag becomes 1 and stays 1 through later reads and writes.
- R7: The overflow flag and the queue pointers are cleared on the first cycle that `hw_en` is sampled high after being low. A conversion strobe or host read in that same cycle is ignored.
- R8: With `hw_en` low, a low read returns {result[3:0], 4'b0000} and a high read returns result[11:4], where result is the latest conversion. The queue is not touched.
- R9: If `rd_lo` and `rd_hi` are asserted in the same cycle, only the low-byte read takes effect.
- R10: `rd_data` changes only on the clock edge that samples a read strobe; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Hardware pacing enable; its rising edge restarts the queue |
| cvt_done | input | 1 | One-cycle conversion-complete strobe |
| cvt_data | input | 12 | Conversion result that accompanies `cvt_done` |
| rd_lo | input | 1 | Host read strobe for the low byte |
| rd_hi | input | 1 | Host read strobe for the high byte |
| rd_data | output | 8 | Registered byte returned for the last read strobe |

## Verification
The tests cover these input patterns:
- A short burst of three samples read back pair by pair. This confirms order, byte layout and pop-on-high.
- An exact fill to `DEPTH`. This separates a full queue from an overflowed one.
- A burst two samples longer than `DEPTH`. This shows which entries are evicted and that the flag stays set.
- Reads after draining. These separate stale-return from popping.
- A restart with a strobe coinciding with the enable edge, followed by software-mode reads. This checks the bypass and the clearing of the flag.
- Simultaneous low and high strobes. This shows that the low read takes priority without popping.

// File: rtl/cvt_fifo_pkg.sv
package cvt_fifo_pkg;
  localparam int SAMPLE_W = 12;
  localparam int BYTE_W   = 8;
  localparam int NIB_W    = SAMPLE_W - BYTE_W;

  typedef logic [SAMPLE_W-1:0] sample_t;

  // low byte: sample nibble on top, two zero bits, overflow, empty
  function automatic logic [BYTE_W-1:0] pack_lo(sample_t s, logic ovf, logic emp);
    return {s[NIB_W-1:0], 2'b00, ovf, emp};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_hi(sample_t s);
    return s[SAMPLE_W-1:NIB_W];
  endfunction
endpackage

// File: rtl/cvt_fifo_mem.sv
module cvt_fifo_mem #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read: distributed RAM so the head is visible in the read cycle
  assign rdata = mem[raddr];
endmodule

// File: rtl/cvt_fifo_ctrl.sv
module cvt_fifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          push,
  input  logic          pop_req,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          drop,
  output logic          ovf
);
  logic full, pop;

  function automatic logic [AW-1:0] step(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign pop   = pop_req & ~empty;
  assign drop  = push & full & ~pop;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop || drop) rptr <= step(rptr);
      if (drop) ovf <= 1'b1;
      case ({push & ~drop, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cvt_sample_fifo.sv
module cvt_sample_fifo
  import cvt_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hw_en,
  input  logic                cvt_done,
  input  logic [SAMPLE_W-1:0] cvt_data,
  input  logic                rd_lo,
  input  logic                rd_hi,
  output logic [BYTE_W-1:0]   rd_data
);
  logic          hw_en_q, start, hw_act, push, hi_only, pop_req;
  logic          lo_taken, empty, drop, ovf;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  sample_t       head, hold, last_wr, sw_res;

  assign start   = hw_en & ~hw_en_q;
  assign hw_act  = hw_en & ~start;
  assign push    = cvt_done & hw_act;
  assign hi_only = rd_hi & ~rd_lo;
  assign pop_req = hi_only & hw_act & lo_taken;

  cvt_fifo_mem #(.DEPTH(DEPTH), .W(SAMPLE_W)) mem_i (
    .clk(clk), .we(push), .waddr(wptr), .wdata(cvt_data),
    .raddr(rptr), .rdata(head)
  );

  cvt_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .restart(start), .push(push), .pop_req(pop_req),
    .wptr(wptr), .rptr(rptr), .count(count), .empty(empty),
    .drop(drop), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_en_q  <= 1'b0;
      rd_data  <= '0;
      hold     <= '0;
      lo_taken <= 1'b0;
      last_wr  <= '0;
      sw_res   <= '0;
    end else begin
      hw_en_q <= hw_en;
      if (cvt_done) sw_res  <= cvt_data;
      if (push)     last_wr <= cvt_data;
      if (start) begin
        lo_taken <= 1'b0;
      end else if (hw_act) begin
        if (rd_lo) begin
          hold     <= empty ? last_wr : head;
          rd_data  <= pack_lo(empty ? last_wr : head, ovf, empty);
          lo_taken <= ~empty & ~drop;
        end else if (hi_only) begin
          rd_data  <= pack_hi(hold);
          lo_taken <= 1'b0;
        end else if (drop) begin
          lo_taken <= 1'b0;
        end
      end else begin
        if (rd_lo)        rd_data <= pack_lo(sw_res, 1'b0, 1'b0);
        else if (hi_only) rd_data <= pack_hi(sw_res);
      end
    end
  end
endmodule

// File: rtl/cvt_sample_fifo_chk.sv
module cvt_sample_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          hw_en,
  input logic          start,
  input logic          rd_lo,
  input logic [7:0]    rd_data,
  input logic [CW-1:0] count,
  input logic          ovf,
  input logic          drop
);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf && !start |=> ovf);
  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf);
  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (count == '0) && !ovf);
  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R8
  sw_flags_chk: assert property (@(posedge clk) disable iff (rst)
    rd_lo && !hw_en |=> rd_data[1:0] == 2'b00);
  // R2
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    rd_lo && !start |=> rd_data[3:2] == 2'b00);
  // R5
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rd_lo && hw_en && !start && count == '0 |=> rd_data[0]);
endmodule

bind cvt_sample_fifo cvt_sample_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .hw_en(hw_en), .start(start), .rd_lo(rd_lo),
  .rd_data(rd_data), .count(count), .ovf(ovf), .drop(drop)
);

// File: tb/cvt_sample_fifo_tb.sv
module cvt_sample_fifo_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_en = 1'b0, cvt_done = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic [11:0] cvt_data = '0;
  logic [7:0]  rd_data;
  int          errs = 0, checks = 0;
  logic [7:0]  b;

  always #5 clk = ~clk;

  cvt_sample_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .hw_en(hw_en), .cvt_done(cvt_done),
    .cvt_data(cvt_data), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data)
  );

  function automatic logic [11:0] smp(int i);
    return 12'(i * 667 + 53);
  endfunction

  function automatic logic [7:0] elo(logic [11:0] d, logic ov, logic em);
    return {d[3:0], 2'b00, ov, em};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic conv(logic [11:0] d);
    cvt_data = d; cvt_done = 1'b1;
    @(negedge clk);
    cvt_done = 1'b0;
  endtask

  task automatic rdlo(output logic [7:0] r);
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0; r = rd_data;
  endtask

  task automatic rdhi(output logic [7:0] r);
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0; r = rd_data;
  endtask

  task automatic hw_on;
    hw_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic hw_off;
    hw_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset rd_data", rd_data, 8'h00);
    hw_on();
    rdlo(b); check("R1 empty after reset", b, 8'h01);
    rdhi(b); check("R5 stale hi after reset", b, 8'h00);
  endtask

  task automatic t_order;
    for (int i = 0; i < 3; i++) conv(smp(i));
    for (int i = 0; i < 3; i++) begin
      rdlo(b); check("R2 low layout", b, elo(smp(i), 1'b0, 1'b0));
      rdhi(b); check("R3 R4 high byte order", b, smp(i)[11:4]);
    end
    rdlo(b); check("R5 stale low", b, elo(smp(2), 1'b0, 1'b1));
    rdhi(b); check("R5 stale high", b, smp(2)[11:4]);
    repeat (3) @(negedge clk);
    check("R10 hold without strobe", rd_data, smp(2)[11:4]);
    rdlo(b); check("R5 no pop when empty", b, elo(smp(2), 1'b0, 1'b1));
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) conv(smp(10 + i));
    for (int i = 0; i < DEPTH; i++) begin
      rdlo(b); check("R4 full low", b, elo(smp(10 + i), 1'b0, 1'b0));
      rdhi(b); check("R4 full high", b, smp(10 + i)[11:4]);
    end
    rdlo(b); check("R4 drained", b, elo(smp(10 + DEPTH - 1), 1'b0, 1'b1));
  endtask

  task automatic t_ovf;
    for (int i = 0; i < DEPTH + 2; i++) conv(smp(40 + i));
    for (int i = 0; i < DEPTH; i++) begin
      rdlo(b); check("R6 overflow low", b, elo(smp(42 + i), 1'b1, 1'b0));
      rdhi(b); check("R6 overflow high", b, smp(42 + i)[11:4]);
    end
    rdlo(b); check("R6 sticky when empty", b, elo(smp(41 + DEPTH), 1'b1, 1'b1));
  endtask

  task automatic t_restart;
    hw_off();
    hw_en = 1'b1; cvt_data = smp(60); cvt_done = 1'b1;
    @(negedge clk);
    cvt_done = 1'b0;
    rdlo(b); check("R7 cleared, start strobe ignored", b, elo(smp(41 + DEPTH), 1'b0, 1'b1));
  endtask

  task automatic t_sw;
    hw_off();
    conv(smp(70));
    rdlo(b); check("R8 sw low", b, {smp(70)[3:0], 4'h0});
    rdhi(b); check("R8 sw high", b, smp(70)[11:4]);
    conv(smp(71));
    rdhi(b); check("R8 sw high direct", b, smp(71)[11:4]);
  endtask

  task automatic t_both;
    hw_on();
    conv(smp(80)); conv(smp(81));
    rd_lo = 1'b1; rd_hi = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0; rd_hi = 1'b0;
    check("R9 both strobes give low", rd_data, elo(smp(80), 1'b0, 1'b0));
    rdlo(b); check("R9 no pop on both", b, elo(smp(80), 1'b0, 1'b0));
    rdhi(b); check("R9 high after", b, smp(80)[11:4]);
    rdlo(b); check("R9 next entry", b, elo(smp(81), 1'b0, 1'b0));
    rdhi(b); check("R9 next high", b, smp(81)[11:4]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R10 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_ovf();
    t_restart();
    t_sw();
    t_both();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule